// File: doc/BRIEF.md
# Multi-Level Trace Trigger Sequencer

This block decides, one sample at a time, which words a logic-capture instrument keeps. It has sixteen levels. At the active level, four comparators test the incoming sample. Each comparator has a value and a care mask. The lowest-numbered comparator that hits supplies a two-bit command. That command either qualifies the sample for storage, ends the recording, jumps to a programmed level, or steps to the next level.

A programmable post-trigger delay sits between the first qualifying hit and the start of tracing. The delay counts either every sample or only qualifying samples. Once tracing is active, every qualified sample leaves the block on a one-cycle write strobe. With the strobe come a wrapping store address and the sample itself, tagged with the level that accepted it.

Software loads patterns, commands and the delay through a single write port. It then pulses `arm` to start a recording at level 0.

Top module: `trace_sequencer`

## Requirements
- R1: A pulse on `arm` takes priority over samples. On the next edge it sets the level to 0, sets `running`, clears `tracing`, clears the delay state and resets the store pointer to 0. After reset the block is idle: `running` = 0, level 0, no stores.
- R2: A comparator hits when `((smp_data ^ value) & mask) == 0`, so bits with mask 0 always match. A sample that hits no comparator at the active level changes nothing except clock-mode delay counting.
- R3: When several comparators hit in one cycle, the one with the lowest index decides the command.
- R4: Command 0 (TRACE) while `tracing` is high produces `cap_we` = 1 on the next edge. `cap_word` = {level, sample}, with the level in the upper 4 bits.
- R5: Command 1 (STOP) clears `running` and `tracing`. The level then stays frozen and samples are ignored until the next `arm`.
- R6: Command 2 (JUMP) loads the comparator's programmed target level.
- R7: Command 3 (ADVANCE) moves to level + 1 and saturates at level 15.
- R8: The first TRACE hit after arm starts the delay and loads the programmed count D. That sample is not stored. With D = 0, `tracing` rises on that same edge. Otherwise, the D-th counted sample after it raises `tracing`, and that sample is not stored either.
- R9: The delay mode bit selects what counts. With the bit at 0, every valid sample counts. With the bit at 1, only samples whose winning command is TRACE count.
- R10: `cap_addr` starts at 0 after arm, increments by one per store and wraps at 2^ADDR_W.
- R11: The register map works as follows. When `cfg_addr[8]` = 1, the write sets the delay count from `cfg_wdata[15:0]` and the mode from `cfg_wdata[16]`. Otherwise `cfg_addr[7:4]` selects the level, `cfg_addr[3:2]` the comparator and `cfg_addr[1:0]` the field: 0 = value, 1 = mask, 2 = command in `cfg_wdata[1:0]` with the target level in `cfg_wdata[7:4]`.
- R12: A cycle with `smp_valid` = 0 changes no level, delay or store state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start a recording at level 0 |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | LVL_W+PAT_W+3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | DATA_W | Sample word |
| level | output | LVL_W | Active sequencer level |
| running | output | 1 | Recording armed and not stopped |
| tracing | output | 1 | Delay expired, storing qualified samples |
| cap_we | output | 1 | Store strobe |
| cap_addr | output | ADDR_W | Store address |
| cap_word | output | LVL_W+DATA_W | Level tag and sample to store |

## Verification
The bench builds the block with DATA_W = 8 and ADDR_W = 3. The byte-wide sample lets a small alphabet of values hit both exact and masked patterns often. The eight-entry store wraps many times inside one recording. Repeated arms under clock-mode, event-mode and zero delays cover the following paths:
- level chains that reach the saturating top level and the stop pattern;
- several comparators overlapping on one value;
- long runs with `smp_valid` held low.

// File: rtl/trace_sequencer.sv
module trace_sequencer #(
  parameter int DATA_W = 16,
  parameter int LVL_W  = 4,
  parameter int PAT_W  = 2,
  parameter int DLY_W  = 16,
  parameter int ADDR_W = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    arm,
  input  logic                    cfg_we,
  input  logic [LVL_W+PAT_W+2:0]  cfg_addr,
  input  logic [31:0]             cfg_wdata,
  input  logic                    smp_valid,
  input  logic [DATA_W-1:0]       smp_data,
  output logic [LVL_W-1:0]        level,
  output logic                    running,
  output logic                    tracing,
  output logic                    cap_we,
  output logic [ADDR_W-1:0]       cap_addr,
  output logic [LVL_W+DATA_W-1:0] cap_word
);
  localparam int NPAT  = 1 << PAT_W;
  localparam int NSLOT = (1 << LVL_W) * NPAT;
  localparam int SW    = LVL_W + PAT_W;
  localparam logic [1:0] C_TRACE = 2'd0, C_STOP = 2'd1, C_JUMP = 2'd2, C_ADV = 2'd3;

  logic [DATA_W-1:0] pval [NSLOT];
  logic [DATA_W-1:0] pmsk [NSLOT];
  logic [1:0]        pcmd [NSLOT];
  logic [LVL_W-1:0]  ptgt [NSLOT];
  logic [DLY_W-1:0]  dly, dcnt;
  logic              dmode, started;
  logic [ADDR_W-1:0] wptr;

  logic             hit;
  logic [PAT_W-1:0] win;
  always_comb begin
    hit = 1'b0;
    win = '0;
    for (int p = NPAT - 1; p >= 0; p--) begin
      if (((smp_data ^ pval[{level, PAT_W'(p)}]) & pmsk[{level, PAT_W'(p)}]) == '0) begin
        hit = 1'b1;
        win = PAT_W'(p);
      end
    end
  end

  wire [SW-1:0]    slot   = {level, win};
  wire [1:0]       cmd    = pcmd[slot];
  wire             is_trc = hit && cmd == C_TRACE;
  wire             counts = started && !tracing && (dmode ? is_trc : 1'b1);
  wire [SW-1:0]    cslot  = cfg_addr[SW+1:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) begin
        pval[i] <= '0;
        pmsk[i] <= '0;
        pcmd[i] <= C_TRACE;
        ptgt[i] <= '0;
      end
      dly   <= '0;
      dmode <= 1'b0;
    end else if (cfg_we) begin
      if (cfg_addr[SW+2]) begin
        dly   <= cfg_wdata[DLY_W-1:0];
        dmode <= cfg_wdata[DLY_W];
      end else begin
        case (cfg_addr[1:0])
          2'd0: pval[cslot] <= cfg_wdata[DATA_W-1:0];
          2'd1: pmsk[cslot] <= cfg_wdata[DATA_W-1:0];
          2'd2: begin
            pcmd[cslot] <= cfg_wdata[1:0];
            ptgt[cslot] <= cfg_wdata[4 +: LVL_W];
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level    <= '0;
      running  <= 1'b0;
      tracing  <= 1'b0;
      started  <= 1'b0;
      dcnt     <= '0;
      wptr     <= '0;
      cap_we   <= 1'b0;
      cap_addr <= '0;
      cap_word <= '0;
    end else begin
      cap_we <= 1'b0;
      if (arm) begin
        level   <= '0;
        running <= 1'b1;
        tracing <= 1'b0;
        started <= 1'b0;
        dcnt    <= '0;
        wptr    <= '0;
      end else if (running && smp_valid) begin
        if (counts) begin
          dcnt <= dcnt - 1'b1;
          if (dcnt <= 1) tracing <= 1'b1;
        end
        if (hit) begin
          case (cmd)
            C_TRACE: begin
              if (tracing) begin
                cap_we   <= 1'b1;
                cap_addr <= wptr;
                cap_word <= {level, smp_data};
                wptr     <= wptr + 1'b1;
              end else if (!started) begin
                started <= 1'b1;
                dcnt    <= dly;
                tracing <= (dly == '0);
              end
            end
            C_STOP: begin
              running <= 1'b0;
              tracing <= 1'b0;
            end
            C_JUMP: level <= ptgt[slot];
            default: if (level != {LVL_W{1'b1}}) level <= level + 1'b1;
          endcase
        end
      end
    end
  end

  assert_arm_home_R1: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (level == '0 && running && !tracing && !cap_we));
  assert_store_while_tracing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_we |-> ($past(tracing) && running));
  assert_tracing_needs_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tracing |-> running);
  assert_stop_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !arm) |=> (level == $past(level) && !cap_we && !tracing));
  assert_idle_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_valid && !arm) |=> ($stable(level) && !cap_we && $stable(running)));
endmodule

// File: tb/sim_trace_sequencer.sv
module sim_trace_sequencer;
  localparam int DW = 8, AW = 3;
  logic clk = 0, rst_n = 0, arm = 0, cfg_we = 0, smp_valid = 0;
  logic [8:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [DW-1:0] smp_data = '0;
  logic [3:0] level;
  logic running, tracing, cap_we;
  logic [AW-1:0] cap_addr;
  logic [DW+3:0] cap_word;

  trace_sequencer #(.DATA_W(DW), .ADDR_W(AW)) u0 (.*);

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  string phase = "R1";

  int mval[64], mmsk[64], mcmd[64], mtgt[64];
  int mdly = 0, mmode = 0;
  int mlevel = 0, mrun = 0, mtr = 0, mstart = 0, mcnt = 0, mwptr = 0;
  int mwe = 0, mword = 0, maddr = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mlevel = 0; mrun = 0; mtr = 0; mstart = 0; mcnt = 0; mwptr = 0; mwe = 0;
      foreach (mval[i]) begin mval[i] = 0; mmsk[i] = 0; mcmd[i] = 0; mtgt[i] = 0; end
      mdly = 0; mmode = 0;
    end else begin
      mwe = 0;
      if (arm) begin
        mlevel = 0; mrun = 1; mtr = 0; mstart = 0; mcnt = 0; mwptr = 0;
      end else if (mrun && smp_valid) begin
        int w, c, tr;
        w = -1;
        for (int p = 0; p < 4; p++)
          if (w < 0 && ((int'(smp_data) ^ mval[mlevel*4+p]) & mmsk[mlevel*4+p]) == 0) w = p;
        c = (w < 0) ? -1 : mcmd[mlevel*4+w];
        tr = mtr;
        if (mstart && !tr && (mmode == 0 || c == 0)) begin
          if (mcnt <= 1) mtr = 1;
          mcnt = mcnt - 1;
        end
        if (c == 0) begin
          if (tr) begin
            mwe = 1; maddr = mwptr; mword = mlevel * 256 + int'(smp_data);
            mwptr = (mwptr + 1) % 8;
          end else if (!mstart) begin
            mstart = 1; mcnt = mdly; mtr = (mdly == 0);
          end
        end else if (c == 1) begin
          mrun = 0; mtr = 0;
        end else if (c == 2) mlevel = mtgt[mlevel*4+w];
        else if (c == 3 && mlevel < 15) mlevel = mlevel + 1;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s/%s actual=%0h expected=%0h", phase, tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk("R6_R7_level", int'(level), mlevel);
    chk("R5_running", int'(running), mrun);
    chk("R8_tracing", int'(tracing), mtr);
    chk("R4_store", int'(cap_we), mwe);
    if (mwe) begin
      chk("R4_word", int'(cap_word), mword);
      chk("R10_addr", int'(cap_addr), maddr);
    end
  endtask

  task automatic wr(int a, int d);
    cfg_we = 1; cfg_addr = 9'(a); cfg_wdata = d; smp_valid = 0; arm = 0;
    if (a >= 256) begin mdly = d & 16'hFFFF; mmode = (d >> 16) & 1; end
    else if ((a & 3) == 0) mval[a >> 2] = d & 8'hFF;
    else if ((a & 3) == 1) mmsk[a >> 2] = d & 8'hFF;
    else if ((a & 3) == 2) begin mcmd[a >> 2] = d & 3; mtgt[a >> 2] = (d >> 4) & 15; end
    step();
    cfg_we = 0;
  endtask

  task automatic setpat(int l, int p, int v, int m, int c, int t);
    wr(l*16 + p*4 + 0, v);
    wr(l*16 + p*4 + 1, m);
    wr(l*16 + p*4 + 2, (t << 4) | c);
  endtask

  function automatic logic [7:0] pick();
    int r = $urandom % 8;
    case (r)
      0: return 8'h10 | 8'($urandom % 16);
      1: return 8'hA5;
      2: return 8'hA0 | 8'($urandom % 16);
      3: return 8'h3C;
      4: return 8'hFF;
      5: return 8'h00;
      default: return 8'($urandom);
    endcase
  endfunction

  task automatic run(int n, int vpct);
    for (int i = 0; i < n; i++) begin
      arm = ($urandom % 40) == 0;
      smp_valid = ($urandom % 100) < vpct;
      smp_data = pick();
      step();
    end
    arm = 0; smp_valid = 0;
  endtask

  task automatic do_arm();
    arm = 1; smp_valid = 1; smp_data = 8'h10;
    step();
    arm = 0; smp_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    phase = "R1";
    step(); step();
    rst_n = 1;
    step();
    do_arm();
    chk("R1_level0", int'(level), 0);
    chk("R1_running", int'(running), 1);

    phase = "R11";
    for (int i = 0; i < 64; i++) setpat(i / 4, i % 4, 8'h55, 8'hFF, 1, 0);
    setpat(0, 0, 8'h10, 8'hF0, 0, 0);
    setpat(0, 1, 8'hA5, 8'hFF, 3, 0);
    setpat(0, 2, 8'hA0, 8'hF0, 2, 7);
    setpat(1, 0, 8'h3C, 8'hFF, 2, 14);
    setpat(1, 1, 8'h00, 8'h00, 0, 0);
    setpat(7, 0, 8'h00, 8'hFF, 1, 0);
    setpat(7, 3, 8'h00, 8'h00, 0, 0);
    setpat(14, 0, 8'h00, 8'h00, 3, 0);
    setpat(15, 0, 8'hFF, 8'hFF, 1, 0);
    setpat(15, 1, 8'h00, 8'h00, 3, 0);
    setpat(15, 2, 8'h00, 8'h00, 0, 0);
    wr(256, 2);

    phase = "R3";
    do_arm(); run(600, 80);
    phase = "R12";
    do_arm(); run(40, 90); run(40, 0);
    phase = "R2";
    wr(256, 0);
    do_arm(); run(600, 70);
    phase = "R9";
    wr(256, (1 << 16) | 3);
    do_arm(); run(800, 85);
    phase = "R5";
    do_arm(); run(300, 100);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule